// File: doc/BRIEF.md
# Byte-Aliased General Register File

This block holds eight 16-bit general registers for a processor datapath. Four of them are data registers. Each data register can also be reached as two separate 8-bit halves. The other four are pointer and index registers, and they are reached only as whole words.

The block has two combinational read ports and one synchronous write port. Each of these ports carries a width select that picks a byte or a word. A dedicated word port loads the data register that receives the upper half of a 32-bit product or quotient. A stepping path moves the two string pointers up or down by the operand size in one clock. The direction of the step comes from a direction input.

Instruction decode and arithmetic sit outside the block. They drive the register codes, the widths and the data.

Top module: `gpr_file`

## Requirements
- R1: While `rst_n` is low, all eight registers read as zero, and they stay zero until the first write.
- R2: In word mode the 3-bit code selects these registers: 0 = A, 1 = C, 2 = D, 3 = B, 4 = stack pointer, 5 = base pointer, 6 = source index, 7 = destination index. A word write stores all 16 bits of `wr_data`.
- R3: In byte mode, codes 0 to 3 select bits 7:0 of A, C, D and B, and codes 4 to 7 select bits 15:8 of A, C, D and B. A byte read returns the byte in bits 7:0 and zeros in bits 15:8.
- R4: A byte write stores `wr_data[7:0]` into the addressed byte only. The other byte of that register keeps its value.
- R5: Both read ports are combinational and independent of each other. During a cycle with a write, a read returns the value the register held before that write.
- R6: When `dxw_en` is high, register D (code 2) takes all 16 bits of `dxw_data` at the clock edge. If the normal write port targets any part of D in the same cycle, `dxw_data` wins. A normal write to any other register in that cycle still takes effect.
- R7: `step_src_en` steps the source index and `step_dst_en` steps the destination index. With `step_dir` = 0 the pointer increases, and with `step_dir` = 1 it decreases. The step is 1 when `step_word` = 0 and 2 when `step_word` = 1, and the result wraps modulo 65536.
- R8: A word write to a pointer on the normal port takes priority over a step of that same pointer in the same cycle. A step of the other pointer still happens.
- R9: No byte code reaches the stack, base, source or destination registers. A byte write with codes 4 to 7 changes only the high byte of A, C, D or B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rda_sel | input | 3 | Read port A register code |
| rda_word | input | 1 | Read port A width: 1 = word, 0 = byte |
| rda_data | output | 16 | Read port A data |
| rdb_sel | input | 3 | Read port B register code |
| rdb_word | input | 1 | Read port B width: 1 = word, 0 = byte |
| rdb_data | output | 16 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_sel | input | 3 | Write port register code |
| wr_word | input | 1 | Write width: 1 = word, 0 = byte |
| wr_data | input | 16 | Write data (byte writes use bits 7:0) |
| dxw_en | input | 1 | Wide-result upper-word write enable into D |
| dxw_data | input | 16 | Upper word of a 32-bit result |
| step_src_en | input | 1 | Step the source index this cycle |
| step_dst_en | input | 1 | Step the destination index this cycle |
| step_dir | input | 1 | 0 = increase, 1 = decrease |
| step_word | input | 1 | Step size: 1 = two, 0 = one |

## Verification
Two pairs of functions can land in the same cycle. The first pair is the upper-word port and the normal write port, both aimed at D. The second pair is a pointer step and a normal word write to that same pointer. The bench raises both sources of each pair on the same clock edge, with both word and byte widths on the normal port. It then reads the register back through a read port and expects the winning source's value. In the same collision cycle, a write to a different register (for R6) or a step of the other pointer (for R8) must still appear. This shows that priority blocks only the collided target.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  localparam int unsigned GPR_W  = 16;
  localparam int unsigned BYTE_W = GPR_W / 2;
  localparam int unsigned CODE_W = 3;

  localparam int unsigned IDX_A   = 0;
  localparam int unsigned IDX_C   = 1;
  localparam int unsigned IDX_D   = 2;
  localparam int unsigned IDX_B   = 3;
  localparam int unsigned IDX_SP  = 4;
  localparam int unsigned IDX_BP  = 5;
  localparam int unsigned IDX_SRC = 6;
  localparam int unsigned IDX_DST = 7;

  typedef enum logic [CODE_W-1:0] {
    CODE_A   = 3'd0,
    CODE_C   = 3'd1,
    CODE_D   = 3'd2,
    CODE_B   = 3'd3,
    CODE_SP  = 3'd4,
    CODE_BP  = 3'd5,
    CODE_SRC = 3'd6,
    CODE_DST = 3'd7
  } gpr_code_e;

  // Step amount for string pointers: one for bytes, two for words.
  function automatic logic [GPR_W-1:0] step_amount(input logic is_word);
    return is_word ? GPR_W'(2) : GPR_W'(1);
  endfunction

  // New pointer value after one step; wraps modulo 2**GPR_W.
  function automatic logic [GPR_W-1:0] step_pointer(
    input logic [GPR_W-1:0] ptr,
    input logic             go_down,
    input logic             is_word
  );
    logic [GPR_W-1:0] amt;
    amt = step_amount(is_word);
    return go_down ? (ptr - amt) : (ptr + amt);
  endfunction

  // Extract the byte a byte-mode code names from a word, zero-extended.
  function automatic logic [GPR_W-1:0] byte_view(
    input logic [GPR_W-1:0] word,
    input logic             upper
  );
    return upper ? {{BYTE_W{1'b0}}, word[GPR_W-1:BYTE_W]}
                 : {{BYTE_W{1'b0}}, word[BYTE_W-1:0]};
  endfunction

endpackage

// File: rtl/gpr_read_port.sv
module gpr_read_port
  import gpr_pkg::*;
#(
  parameter int unsigned DATA_W = GPR_W,
  parameter int unsigned SEL_W  = CODE_W,
  localparam int unsigned NREG  = 2 ** SEL_W,
  localparam int unsigned HALF  = DATA_W / 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NREG-1:0][DATA_W-1:0]  regs_q,
  input  logic [SEL_W-1:0]             sel,
  input  logic                         word,
  output logic [DATA_W-1:0]            data
);

  logic [SEL_W-2:0]   lane_reg;
  logic               lane_upper;
  logic [DATA_W-1:0]  lane_word;

  assign lane_reg   = sel[SEL_W-2:0];
  assign lane_upper = sel[SEL_W-1];
  assign lane_word  = regs_q[lane_reg];

  always_comb begin
    if (word) data = regs_q[sel];
    else      data = byte_view(lane_word, lane_upper);
  end

  // R3: a byte read never carries anything in its upper half
  assert_byte_zero_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !word |-> (data[DATA_W-1:HALF] == '0));

  // R2: a word read of a pointer code follows the named register
  assert_word_pick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (word && sel == SEL_W'(IDX_SRC)) |-> (data == regs_q[IDX_SRC]));

endmodule

// File: rtl/gpr_str_step.sv
module gpr_str_step
  import gpr_pkg::*;
(
  input  logic [GPR_W-1:0] ptr_q,
  input  logic             go_down,
  input  logic             is_word,
  output logic [GPR_W-1:0] ptr_d
);

  assign ptr_d = step_pointer(ptr_q, go_down, is_word);

endmodule

// File: rtl/gpr_write_ctrl.sv
module gpr_write_ctrl
  import gpr_pkg::*;
#(
  parameter int unsigned DATA_W = GPR_W,
  parameter int unsigned SEL_W  = CODE_W,
  localparam int unsigned NREG  = 2 ** SEL_W,
  localparam int unsigned NDATA = NREG / 2,
  localparam int unsigned HALF  = DATA_W / 2
) (
  input  logic [NREG-1:0][DATA_W-1:0]  cur_q,
  input  logic                         wr_en,
  input  logic [SEL_W-1:0]             wr_sel,
  input  logic                         wr_word,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         dxw_en,
  input  logic [DATA_W-1:0]            dxw_data,
  input  logic [1:0]                   step_go,
  input  logic [1:0][DATA_W-1:0]       step_val,
  output logic [NREG-1:0][DATA_W-1:0]  nxt_q,
  output logic [NREG-1:0]              upd,
  output logic                         dx_collide,
  output logic [1:0]                   step_blocked
);

  logic [NREG-1:0] word_hit;
  logic [NREG-1:0] lo_hit;
  logic [NREG-1:0] hi_hit;

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign word_hit[g] = wr_en && wr_word && (wr_sel == SEL_W'(g));
    if (g < NDATA) begin : g_data
      assign lo_hit[g] = wr_en && !wr_word && !wr_sel[SEL_W-1]
                         && (wr_sel[SEL_W-2:0] == (SEL_W-1)'(g));
      assign hi_hit[g] = wr_en && !wr_word &&  wr_sel[SEL_W-1]
                         && (wr_sel[SEL_W-2:0] == (SEL_W-1)'(g));
    end else begin : g_ptr
      assign lo_hit[g] = 1'b0;
      assign hi_hit[g] = 1'b0;
    end
  end

  assign dx_collide = dxw_en && (word_hit[IDX_D] || lo_hit[IDX_D] || hi_hit[IDX_D]);
  assign step_blocked[0] = step_go[0] && word_hit[IDX_SRC];
  assign step_blocked[1] = step_go[1] && word_hit[IDX_DST];

  // Priority, lowest first: pointer step, port write, upper-word write.
  always_comb begin
    nxt_q = cur_q;
    upd   = '0;
    for (int r = 0; r < int'(NREG); r++) begin
      if (r == int'(IDX_SRC) && step_go[0]) begin
        nxt_q[r] = step_val[0];
        upd[r]   = 1'b1;
      end
      if (r == int'(IDX_DST) && step_go[1]) begin
        nxt_q[r] = step_val[1];
        upd[r]   = 1'b1;
      end
      if (word_hit[r]) begin
        nxt_q[r] = wr_data;
        upd[r]   = 1'b1;
      end
      if (lo_hit[r]) begin
        nxt_q[r][HALF-1:0] = wr_data[HALF-1:0];
        upd[r]             = 1'b1;
      end
      if (hi_hit[r]) begin
        nxt_q[r][DATA_W-1:HALF] = wr_data[HALF-1:0];
        upd[r]                  = 1'b1;
      end
      if (r == int'(IDX_D) && dxw_en) begin
        nxt_q[r] = dxw_data;
        upd[r]   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_pkg::*;
#(
  parameter int unsigned DATA_W = GPR_W,
  parameter int unsigned SEL_W  = CODE_W,
  localparam int unsigned NREG  = 2 ** SEL_W,
  localparam int unsigned HALF  = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  rda_sel,
  input  logic              rda_word,
  output logic [DATA_W-1:0] rda_data,
  input  logic [SEL_W-1:0]  rdb_sel,
  input  logic              rdb_word,
  output logic [DATA_W-1:0] rdb_data,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dxw_en,
  input  logic [DATA_W-1:0] dxw_data,
  input  logic              step_src_en,
  input  logic              step_dst_en,
  input  logic              step_dir,
  input  logic              step_word
);

  logic [NREG-1:0][DATA_W-1:0] regs_q;
  logic [NREG-1:0][DATA_W-1:0] regs_d;
  logic [NREG-1:0]             regs_upd;
  logic [1:0][DATA_W-1:0]      step_val;
  logic [1:0]                  step_go;
  logic                        dx_collide;
  logic [1:0]                  step_blocked;

  assign step_go = {step_dst_en, step_src_en};

  for (genvar p = 0; p < 2; p++) begin : g_step
    gpr_str_step u_step (
      .ptr_q   (regs_q[IDX_SRC + p]),
      .go_down (step_dir),
      .is_word (step_word),
      .ptr_d   (step_val[p])
    );
  end

  gpr_write_ctrl #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_wctl (
    .cur_q        (regs_q),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_word      (wr_word),
    .wr_data      (wr_data),
    .dxw_en       (dxw_en),
    .dxw_data     (dxw_data),
    .step_go      (step_go),
    .step_val     (step_val),
    .nxt_q        (regs_d),
    .upd          (regs_upd),
    .dx_collide   (dx_collide),
    .step_blocked (step_blocked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else begin
      for (int r = 0; r < int'(NREG); r++) begin
        if (regs_upd[r]) regs_q[r] <= regs_d[r];
      end
    end
  end

  gpr_read_port #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_rda (
    .clk (clk), .rst_n (rst_n), .regs_q (regs_q),
    .sel (rda_sel), .word (rda_word), .data (rda_data)
  );

  gpr_read_port #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_rdb (
    .clk (clk), .rst_n (rst_n), .regs_q (regs_q),
    .sel (rdb_sel), .word (rdb_word), .data (rdb_data)
  );

  // R1: register state is cleared for as long as reset is held
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (regs_q == '0));

  // R6: the upper-word port always lands in D, collision or not
  assert_dxw_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dxw_en |=> (regs_q[IDX_D] == $past(dxw_data)));

  // R6: a collision still leaves D equal to the upper-word data
  assert_dx_collide_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dx_collide |=> (regs_q[IDX_D] != $past(wr_data) || $past(wr_data) == $past(dxw_data)
                    || !$past(wr_word)));

  // R4: a byte write keeps the other byte of its register
  assert_byte_keep_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_word && !dxw_en && !wr_sel[SEL_W-1])
    |=> (regs_q[$past(wr_sel[SEL_W-2:0])][DATA_W-1:HALF]
         == $past(regs_q[wr_sel[SEL_W-2:0]][DATA_W-1:HALF])));

  assert_byte_keep_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_word && !dxw_en && wr_sel[SEL_W-1])
    |=> (regs_q[$past(wr_sel[SEL_W-2:0])][HALF-1:0]
         == $past(regs_q[wr_sel[SEL_W-2:0]][HALF-1:0])));

  // R7: an unblocked source step moves the pointer by exactly one or two
  assert_src_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_src_en && !step_blocked[0])
    |=> ($past(step_dir)
          ? (DATA_W'(regs_q[IDX_SRC] + ($past(step_word) ? 2 : 1)) == $past(regs_q[IDX_SRC]))
          : (regs_q[IDX_SRC] == DATA_W'($past(regs_q[IDX_SRC]) + ($past(step_word) ? 2 : 1)))));

  // R8: a port write to a pointer overrides that pointer's step
  assert_wr_over_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_blocked[1] |=> (regs_q[IDX_DST] == $past(wr_data)));

  // R9: stack and base pointers move only on a word write to their own code
  assert_sp_bp_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_word && (wr_sel == SEL_W'(IDX_SP) || wr_sel == SEL_W'(IDX_BP)))
    |=> ($stable(regs_q[IDX_SP]) && $stable(regs_q[IDX_BP])));

endmodule

// File: tb/gpr_file_tb.sv
`timescale 1ns/100ps
module gpr_file_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  rda_sel = '0, rdb_sel = '0, wr_sel = '0;
  logic        rda_word = 1'b1, rdb_word = 1'b1, wr_word = 1'b1;
  logic        wr_en = 1'b0, dxw_en = 1'b0;
  logic [15:0] wr_data = '0, dxw_data = '0;
  logic        step_src_en = 1'b0, step_dst_en = 1'b0, step_dir = 1'b0, step_word = 1'b0;
  logic [15:0] rda_data, rdb_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gpr_file u_dut (
    .clk (clk), .rst_n (rst_n),
    .rda_sel (rda_sel), .rda_word (rda_word), .rda_data (rda_data),
    .rdb_sel (rdb_sel), .rdb_word (rdb_word), .rdb_data (rdb_data),
    .wr_en (wr_en), .wr_sel (wr_sel), .wr_word (wr_word), .wr_data (wr_data),
    .dxw_en (dxw_en), .dxw_data (dxw_data),
    .step_src_en (step_src_en), .step_dst_en (step_dst_en),
    .step_dir (step_dir), .step_word (step_word)
  );

  // Vector: {we, wsel[3], wword, wdata[16], rsel[3], rword, expect[16]}
  localparam logic [40:0] VEC [0:15] = '{
    {1'b1, 3'd0, 1'b1, 16'h1234, 3'd0, 1'b1, 16'h1234},  // R2 word A
    {1'b1, 3'd4, 1'b0, 16'h00AB, 3'd0, 1'b1, 16'hAB34},  // R4 high byte of A
    {1'b1, 3'd0, 1'b0, 16'hFFCD, 3'd0, 1'b0, 16'h00CD},  // R3 low byte of A
    {1'b0, 3'd0, 1'b0, 16'h0000, 3'd4, 1'b0, 16'h00AB},  // R3 read high byte A
    {1'b1, 3'd1, 1'b1, 16'hBEEF, 3'd5, 1'b0, 16'h00BE},  // R3 C high byte
    {1'b1, 3'd1, 1'b0, 16'h0011, 3'd1, 1'b1, 16'hBE11},  // R4 C low byte
    {1'b1, 3'd2, 1'b1, 16'h5A5A, 3'd6, 1'b0, 16'h005A},  // R3 D high byte
    {1'b1, 3'd3, 1'b1, 16'h0F0F, 3'd3, 1'b1, 16'h0F0F},  // R2 word B
    {1'b1, 3'd7, 1'b0, 16'h0077, 3'd3, 1'b1, 16'h770F},  // R4 B high byte
    {1'b1, 3'd4, 1'b1, 16'hFFFE, 3'd4, 1'b1, 16'hFFFE},  // R2 stack pointer
    {1'b1, 3'd4, 1'b0, 16'h0099, 3'd4, 1'b1, 16'hFFFE},  // R9 byte code 4 spares SP
    {1'b0, 3'd0, 1'b0, 16'h0000, 3'd0, 1'b1, 16'h99CD},  // R9 it hit A high
    {1'b1, 3'd5, 1'b1, 16'h8000, 3'd5, 1'b1, 16'h8000},  // R2 base pointer
    {1'b1, 3'd6, 1'b1, 16'h0010, 3'd6, 1'b1, 16'h0010},  // R2 source index
    {1'b1, 3'd7, 1'b1, 16'h0020, 3'd7, 1'b1, 16'h0020},  // R2 destination index
    {1'b0, 3'd0, 1'b0, 16'h0000, 3'd3, 1'b0, 16'h000F}   // R3 low byte of B
  };

  function automatic logic [15:0] ref_step(input logic [15:0] v, input logic down, input logic wide);
    int delta;
    delta = wide ? 2 : 1;
    if (down) delta = -delta;
    return 16'((int'(v) + delta + 65536) % 65536);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; dxw_en = 1'b0; step_src_en = 1'b0; step_dst_en = 1'b0;
  endtask

  task automatic write_word(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_word = 1'b1; wr_data = d;
    @(posedge clk); #1 idle_inputs();
  endtask

  task automatic read_a(input logic [2:0] sel, input logic word, output logic [15:0] v);
    rda_sel = sel; rda_word = word; #1 v = rda_data;
  endtask

  initial begin
    logic [15:0] v;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    // R1: reset state on every register
    for (int r = 0; r < 8; r++) begin
      read_a(3'(r), 1'b1, v);
      chk("R1 reset", v, 16'h0000);
    end
    @(negedge clk) rst_n = 1'b1;

    // Vector table
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      wr_en = VEC[i][40]; wr_sel = VEC[i][39:37]; wr_word = VEC[i][36]; wr_data = VEC[i][35:20];
      @(posedge clk); #1 idle_inputs();
      rda_sel = VEC[i][19:17]; rda_word = VEC[i][16];
      rdb_sel = VEC[i][19:17]; rdb_word = VEC[i][16];
      #1;
      chk($sformatf("R2/R3/R4/R9 vec%0d portA", i), rda_data, VEC[i][15:0]);
      chk($sformatf("R5 vec%0d portB", i), rdb_data, VEC[i][15:0]);
    end

    // R5: independent ports and read-before-write within a cycle
    @(negedge clk);
    rda_sel = 3'd0; rda_word = 1'b1; rdb_sel = 3'd5; rdb_word = 1'b1;
    wr_en = 1'b1; wr_sel = 3'd0; wr_word = 1'b1; wr_data = 16'hAAAA;
    #1;
    chk("R5 old value during write", rda_data, 16'h99CD);
    chk("R5 port B other reg", rdb_data, 16'h8000);
    @(posedge clk); #1 idle_inputs(); #1;
    chk("R5 new value after edge", rda_data, 16'hAAAA);

    // R6: upper-word port beats a word write to D; A written in parallel elsewhere
    @(negedge clk);
    dxw_en = 1'b1; dxw_data = 16'h2222;
    wr_en = 1'b1; wr_sel = 3'd2; wr_word = 1'b1; wr_data = 16'h1111;
    @(posedge clk); #1 idle_inputs();
    read_a(3'd2, 1'b1, v); chk("R6 word collision", v, 16'h2222);
    // R6: against a byte write to D high
    @(negedge clk);
    dxw_en = 1'b1; dxw_data = 16'h3C3C;
    wr_en = 1'b1; wr_sel = 3'd6; wr_word = 1'b0; wr_data = 16'h00EE;
    @(posedge clk); #1 idle_inputs();
    read_a(3'd2, 1'b1, v); chk("R6 byte collision", v, 16'h3C3C);
    // R6: non-colliding write to A lands
    @(negedge clk);
    dxw_en = 1'b1; dxw_data = 16'h4444;
    wr_en = 1'b1; wr_sel = 3'd0; wr_word = 1'b1; wr_data = 16'h5555;
    @(posedge clk); #1 idle_inputs();
    read_a(3'd2, 1'b1, v); chk("R6 D from upper port", v, 16'h4444);
    read_a(3'd0, 1'b1, v); chk("R6 A written same cycle", v, 16'h5555);

    // R7: pointer stepping
    write_word(3'd6, 16'h0010);
    write_word(3'd7, 16'h0020);
    @(negedge clk);
    step_src_en = 1'b1; step_dst_en = 1'b1; step_dir = 1'b0; step_word = 1'b1;
    @(posedge clk); #1 idle_inputs();
    read_a(3'd6, 1'b1, v); chk("R7 src word up", v, ref_step(16'h0010, 1'b0, 1'b1));
    read_a(3'd7, 1'b1, v); chk("R7 dst word up", v, ref_step(16'h0020, 1'b0, 1'b1));
    @(negedge clk);
    step_src_en = 1'b1; step_dir = 1'b1; step_word = 1'b0;
    @(posedge clk); #1 idle_inputs();
    read_a(3'd6, 1'b1, v); chk("R7 src byte down", v, ref_step(16'h0012, 1'b1, 1'b0));
    read_a(3'd7, 1'b1, v); chk("R7 dst untouched", v, 16'h0022);
    // R7: wrap both ways
    write_word(3'd6, 16'hFFFF);
    write_word(3'd7, 16'h0000);
    @(negedge clk);
    step_src_en = 1'b1; step_dir = 1'b0; step_word = 1'b1;
    @(posedge clk); #1 idle_inputs();
    @(negedge clk);
    step_dst_en = 1'b1; step_dir = 1'b1; step_word = 1'b0;
    @(posedge clk); #1 idle_inputs();
    read_a(3'd6, 1'b1, v); chk("R7 wrap up", v, 16'h0001);
    read_a(3'd7, 1'b1, v); chk("R7 wrap down", v, 16'hFFFF);

    // R8: port write overrides a step of the same pointer, other pointer still steps
    @(negedge clk);
    step_src_en = 1'b1; step_dst_en = 1'b1; step_dir = 1'b0; step_word = 1'b0;
    wr_en = 1'b1; wr_sel = 3'd6; wr_word = 1'b1; wr_data = 16'h5000;
    @(posedge clk); #1 idle_inputs();
    read_a(3'd6, 1'b1, v); chk("R8 write wins", v, 16'h5000);
    read_a(3'd7, 1'b1, v); chk("R8 other pointer steps", v, ref_step(16'hFFFF, 1'b0, 1'b0));

    // R1: reset clears again mid-run
    @(negedge clk) rst_n = 1'b0;
    #1 read_a(3'd0, 1'b1, v); chk("R1 reset mid-run", v, 16'h0000);
    @(negedge clk) rst_n = 1'b1;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule